// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Responder

This block is the identity layer of a slave on a single-wire open-drain bus. It sits above a bit-slot engine that turns bus waveforms into clean strobes: a reset-pulse strobe, a write strobe with the bit the master wrote, and a read strobe marking each read slot the master opened. In return it tells that engine when to answer a reset with a presence pulse, and whether to pull the line low during the next read slot. It holds a fixed 64-bit identity. The low byte is a family code, the next 48 bits are a serial number, and the top byte is a CRC.

After each reset the block takes an 8-bit command. It then does one of three things. It can read out its identity. It can compare a 64-bit address written by the master against its identity. It can join a bit-by-bit search, dropping out as soon as the master picks a value that differs from its own bit. When it is addressed successfully it raises `selected`, which hands the bus to a function-command layer. The block also watches the raw line level. A line held low for longer than a set number of cycles counts as a reset, even if the slot engine reported none.

Top module: `ow_rom_responder`

## Requirements
- R1: A reset event is either a `rst_pulse` strobe or a long-low detection (R2). It aborts any transaction, clears `selected`, raises `presence` for exactly the next clock cycle, and starts command reception. Before the first reset event after `rst_n`, all writes and read slots are ignored: `pull_dn` stays 0 and `selected` stays 0.
- R2: If `line_low` is sampled high on LONG_LOW_CYC+1 consecutive rising edges, that is a reset event. It fires once per low period. A low period of LONG_LOW_CYC cycles or fewer has no effect.
- R3: A command is the next 8 written bits after a reset event, least significant bit first. The codes are 33h (read), 55h (match) and F0h (search).
- R4: Read (33h). During read slot i (i = 0..63) the block sends bit i of ROM_ID. `pull_dn` is 1 exactly when that bit is 0, and each `rd_strb` moves on to the next bit. `selected` is 1 from the cycle after the 64th read slot.
- R5: Match (55h). The next 64 written bits are compared with ROM_ID bits 0..63 in order. `selected` is 1 from the cycle after the 64th bit, provided all 64 bits matched.
- R6: On a match mismatch the block ignores all traffic until the next reset event. `pull_dn` stays 0 and `selected` stays 0.
- R7: Search (F0h). For each bit i, the first read slot carries bit i and the second carries its complement. The next write is then compared with bit i. If they are equal the block moves to bit i+1, and after bit 63 `selected` becomes 1.
- R8: If a search write differs from the block's bit, the block releases the bus (`pull_dn` = 0) for every later slot until a reset event, and `selected` stays 0.
- R9: Any other command code makes the block ignore all traffic until the next reset event, with no drive and no selection.
- R10: While `selected` is 1 the block never drives `pull_dn`, and a reset event clears `selected`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| rst_pulse | input | 1 | Strobe from the slot engine: the master sent a bus reset |
| line_low | input | 1 | Synchronised raw bus level, 1 while the line is low |
| wr_strb | input | 1 | Strobe: the master completed a write slot |
| wr_bit | input | 1 | Bit value of that write slot |
| rd_strb | input | 1 | Strobe: the master completed a read slot |
| presence | output | 1 | One-cycle request for the slot engine to send a presence pulse |
| pull_dn | output | 1 | Pull the line low in the coming read slot (sends a 0) |
| selected | output | 1 | Slave addressed; control passes to the function layer |

## Verification
The bench builds the block with a 64-bit identity that mixes ones and zeros in every byte, and with LONG_LOW_CYC set to 20. That small limit puts both sides of the long-low boundary within a few cycles, so a low period of exactly 20 cycles and one of 21 are both tested directly. Random match addresses and random search choices flip a single bit at positions anywhere from 0 to 63. This covers drop-out at the first bit, at the last bit and in between, as well as the full success paths.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,  // waiting for a reset event
    ST_CMD    = 3'd1,  // collecting command bits
    ST_READ   = 3'd2,  // sending identity
    ST_MATCH  = 3'd3,  // comparing written address
    ST_SBIT   = 3'd4,  // search: send true bit
    ST_SCOMP  = 3'd5,  // search: send complement
    ST_SPICK  = 3'd6,  // search: take master choice
    ST_SEL    = 3'd7   // addressed
  } rom_state_t;

  localparam logic [7:0] CODE_READ   = 8'h33;
  localparam logic [7:0] CODE_MATCH  = 8'h55;
  localparam logic [7:0] CODE_SEARCH = 8'hF0;

  function automatic rom_state_t decode_cmd(input logic [7:0] code);
    case (code)
      CODE_READ:   return ST_READ;
      CODE_MATCH:  return ST_MATCH;
      CODE_SEARCH: return ST_SBIT;
      default:     return ST_IDLE;
    endcase
  endfunction

  function automatic logic drives_bus(input rom_state_t s);
    return (s == ST_READ) || (s == ST_SBIT) || (s == ST_SCOMP);
  endfunction

endpackage

// File: rtl/ow_long_low.sv
module ow_long_low #(
  parameter int unsigned LIMIT = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_low,
  output logic fire
);
  localparam int unsigned CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);
  localparam logic [CW-1:0] HIT = CW'(LIMIT);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!line_low) begin
      low_cnt <= '0;
    end else if (low_cnt != SAT) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign fire = line_low && (low_cnt == HIT);

  AST_FIRE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (line_low && $past(line_low))) else $error("long-low fired early"); // R2
  AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire) else $error("long-low fired twice"); // R2

endmodule

// File: rtl/ow_cmd_shift.sv
module ow_cmd_shift #(
  parameter int unsigned CMD_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                shift_en,
  input  logic                bit_in,
  output logic                done,
  output logic [CMD_BITS-1:0] code
);
  localparam int unsigned CW = $clog2(CMD_BITS);
  localparam logic [CW-1:0] LAST = CW'(CMD_BITS - 1);

  logic [CMD_BITS-1:0] sr;
  logic [CW-1:0]       cnt;

  // LSB arrives first, so new bits enter at the top and move down
  assign code = {bit_in, sr[CMD_BITS-1:1]};
  assign done = shift_en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clear) begin
      sr  <= '0;
      cnt <= '0;
    end else if (shift_en) begin
      sr  <= code;
      cnt <= done ? '0 : cnt + 1'b1;
    end
  end

  AST_CMD_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> (cnt == '0)) else $error("command counter did not wrap"); // R3

endmodule

// File: rtl/ow_rom_responder.sv
module ow_rom_responder
  import ow_rom_pkg::*;
#(
  parameter int unsigned ID_BITS      = 64,
  parameter logic [63:0] ROM_ID       = 64'hB7A1_2C9E_4F30_6D28,
  parameter int unsigned LONG_LOW_CYC = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pulse,
  input  logic line_low,
  input  logic wr_strb,
  input  logic wr_bit,
  input  logic rd_strb,
  output logic presence,
  output logic pull_dn,
  output logic selected
);
  localparam int unsigned CMD_BITS = 8;
  localparam int unsigned IW       = $clog2(ID_BITS);
  localparam logic [IW-1:0] LAST_IX = IW'(ID_BITS - 1);

  function automatic logic id_at(input logic [IW-1:0] ix);
    return ROM_ID[ix];
  endfunction

  rom_state_t          state;
  logic [IW-1:0]       idx;
  logic                long_fire;
  logic                rst_evt;
  logic                cmd_done;
  logic [CMD_BITS-1:0] cmd_code;
  logic                cur_bit;
  logic                last_bit;
  logic                match_miss;
  logic                srch_miss;
  logic                tx_bit;

  ow_long_low #(.LIMIT(LONG_LOW_CYC)) u_long_low (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_low (line_low),
    .fire     (long_fire)
  );

  assign rst_evt = rst_pulse || long_fire;

  ow_cmd_shift #(.CMD_BITS(CMD_BITS)) u_cmd_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (rst_evt),
    .shift_en (wr_strb && (state == ST_CMD)),
    .bit_in   (wr_bit),
    .done     (cmd_done),
    .code     (cmd_code)
  );

  assign cur_bit    = id_at(idx);
  assign last_bit   = (idx == LAST_IX);
  assign match_miss = (state == ST_MATCH) && wr_strb && (wr_bit != cur_bit);
  assign srch_miss  = (state == ST_SPICK) && wr_strb && (wr_bit != cur_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      presence <= 1'b0;
    end else begin
      presence <= rst_evt;
      if (rst_evt) begin
        state <= ST_CMD;
        idx   <= '0;
      end else begin
        unique case (state)
          ST_CMD: if (cmd_done) begin
            state <= decode_cmd(cmd_code);
            idx   <= '0;
          end
          ST_READ: if (rd_strb) begin
            if (last_bit) state <= ST_SEL;
            else          idx   <= idx + 1'b1;
          end
          ST_MATCH: if (wr_strb) begin
            if (match_miss)    state <= ST_IDLE;
            else if (last_bit) state <= ST_SEL;
            else               idx   <= idx + 1'b1;
          end
          ST_SBIT:  if (rd_strb) state <= ST_SCOMP;
          ST_SCOMP: if (rd_strb) state <= ST_SPICK;
          ST_SPICK: if (wr_strb) begin
            if (srch_miss) begin
              state <= ST_IDLE;
            end else if (last_bit) begin
              state <= ST_SEL;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_SBIT;
            end
          end
          default: state <= state;
        endcase
      end
    end
  end

  assign tx_bit   = (state == ST_SCOMP) ? !cur_bit : cur_bit;
  assign pull_dn  = drives_bus(state) && !tx_bit;
  assign selected = (state == ST_SEL);

  AST_RESET_PRESENCE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (presence && !selected && !pull_dn)) else $error("reset handling"); // R1
  AST_PRESENCE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    presence |-> $past(rst_evt)) else $error("stray presence"); // R1
  AST_MATCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (match_miss && !rst_evt) |=> (!selected && !pull_dn)) else $error("match miss kept"); // R6
  AST_SEARCH_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_SCOMP) && ($past(state) == ST_SBIT)) |-> (pull_dn != $past(pull_dn)))
    else $error("complement slot wrong"); // R7
  AST_SEARCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_miss && !rst_evt) |=> (!selected && !pull_dn)) else $error("search miss kept"); // R8
  AST_SEL_FULL_ID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> ($past(last_bit) && $past(wr_strb || rd_strb)))
    else $error("selected before full id"); // R5
  AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && rd_strb) |-> !pull_dn) else $error("drive while selected"); // R10

endmodule

// File: tb/ow_rom_responder_tb.sv
module ow_rom_responder_tb_top;
  localparam logic [63:0] ID  = 64'h5AC3_1E87_D24B_960F;
  localparam int unsigned LLC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_pulse = 1'b0, line_low = 1'b0;
  logic wr_strb = 1'b0, wr_bit = 1'b0, rd_strb = 1'b0;
  logic presence, pull_dn, selected;
  int n_chk = 0, n_err = 0;

  always #5ns clk = ~clk;

  ow_rom_responder #(.ID_BITS(64), .ROM_ID(ID), .LONG_LOW_CYC(LLC)) dut_i (
    .clk(clk), .rst_n(rst_n), .rst_pulse(rst_pulse), .line_low(line_low),
    .wr_strb(wr_strb), .wr_bit(wr_bit), .rd_strb(rd_strb),
    .presence(presence), .pull_dn(pull_dn), .selected(selected)
  );

  // bench view: a read slot pulls low when the bit to send is zero
  function automatic logic exp_pull(input logic b);
    return (b == 1'b0);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic b);
    @(negedge clk); wr_strb = 1'b1; wr_bit = b;
    @(negedge clk); wr_strb = 1'b0;
  endtask

  task automatic rd(output logic pd);
    @(negedge clk); pd = pull_dn; rd_strb = 1'b1;
    @(negedge clk); rd_strb = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) wr(c[i]);
  endtask

  task automatic bus_reset();
    @(negedge clk); rst_pulse = 1'b1;
    @(negedge clk); rst_pulse = 1'b0;
    chk("R1 presence", presence, 1'b1);
    chk("R1 sel clear", selected, 1'b0);
    @(negedge clk);
    chk("R1 presence one cycle", presence, 1'b0);
  endtask

  task automatic do_read();
    logic pd;
    send_cmd(8'h33);
    for (int i = 0; i < 64; i++) begin
      rd(pd);
      chk($sformatf("R4 bit %0d", i), pd, exp_pull(ID[i]));
    end
    chk("R4 selected", selected, 1'b1);
  endtask

  task automatic do_match(input logic [63:0] addr);
    logic pd;
    send_cmd(8'h55);
    for (int i = 0; i < 64; i++) wr(addr[i]);
    chk("R5 match result", selected, addr == ID);
    rd(pd);
    chk("R6 no drive after match", pd, 1'b0);
  endtask

  task automatic do_search(input logic flip, input int pos);
    logic a, b, m, dropped;
    dropped = 1'b0;
    send_cmd(8'hF0);
    for (int i = 0; i < 64; i++) begin
      rd(a); rd(b);
      if (!dropped) begin
        chk($sformatf("R7 true bit %0d", i), a, exp_pull(ID[i]));
        chk($sformatf("R7 compl bit %0d", i), b, exp_pull(!ID[i]));
      end else begin
        chk($sformatf("R8 released %0d", i), {a, b}, 2'b00);
      end
      m = ID[i] ^ (flip && (i == pos));
      wr(m);
      if (m != ID[i]) dropped = 1'b1;
    end
    chk("R7 R8 search result", selected, !dropped);
  endtask

  task automatic do_unknown(input logic [7:0] c);
    logic pd;
    send_cmd(c);
    for (int i = 0; i < 8; i++) begin
      rd(pd);
      chk("R9 no drive", pd, 1'b0);
    end
    send_cmd(8'h55);
    for (int i = 0; i < 64; i++) wr(ID[i]);
    chk("R9 no selection", selected, 1'b0);
  endtask

  initial begin
    #2_000_000ns;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic pd;
    int unsigned seed;
    seed = $urandom(32'h0051_7E3D);
    repeat (3) @(negedge clk);
    chk("R1 reset presence", presence, 1'b0);
    chk("R1 reset selected", selected, 1'b0);
    chk("R1 reset pull", pull_dn, 1'b0);
    rst_n = 1'b1;

    // commands before any bus reset are ignored
    send_cmd(8'h33);
    for (int i = 0; i < 4; i++) begin rd(pd); chk("R1 pre-reset no drive", pd, 1'b0); end

    bus_reset(); do_read();
    // R10: no drive while selected
    for (int i = 0; i < 3; i++) begin rd(pd); chk("R10 quiet when selected", pd, 1'b0); end
    bus_reset(); chk("R10 cleared", selected, 1'b0);

    // R2: exactly LLC low cycles is harmless
    bus_reset(); do_read();
    @(negedge clk); line_low = 1'b1;
    repeat (LLC) @(negedge clk);
    line_low = 1'b0;
    @(negedge clk);
    chk("R2 short low keeps sel", selected, 1'b1);
    chk("R2 short low no presence", presence, 1'b0);
    // LLC+1 low cycles is a reset
    @(negedge clk); line_low = 1'b1;
    repeat (LLC) @(negedge clk);
    chk("R2 before limit", presence, 1'b0);
    @(negedge clk);
    chk("R2 long low presence", presence, 1'b1);
    chk("R2 long low clears sel", selected, 1'b0);
    repeat (3) @(negedge clk);
    chk("R2 fires once", presence, 1'b0);
    line_low = 1'b0;
    do_read();

    // R1: abort mid-read, then a fresh command works
    bus_reset(); send_cmd(8'h33);
    for (int i = 0; i < 10; i++) rd(pd);
    bus_reset(); do_match(ID);

    // R3: bit order — 33h sent MSB first arrives as CCh
    bus_reset(); do_unknown(8'hCC);

    // corner search drops at first and last bit, match miss at both ends
    bus_reset(); do_search(1'b1, 0);
    bus_reset(); do_search(1'b1, 63);
    bus_reset(); do_search(1'b0, 0);
    bus_reset(); do_match(ID ^ 64'h1);
    bus_reset(); do_match(ID ^ (64'h1 << 63));

    for (int it = 0; it < 24; it++) begin
      int unsigned k, pos;
      logic flip;
      logic [7:0] c;
      k = $urandom_range(0, 3);
      pos = $urandom_range(0, 63);
      flip = 1'($urandom_range(0, 1));
      bus_reset();
      case (k)
        0: do_read();
        1: do_match(flip ? (ID ^ (64'h1 << pos)) : ID);
        2: do_search(flip, int'(pos));
        default: begin
          c = 8'($urandom);
          if (c == 8'h33 || c == 8'h55 || c == 8'hF0) c = 8'hA5;
          do_unknown(c);
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule